// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Capture Unit

This unit watches a port of input pins and raises an interrupt when an enabled pin changes state. Each pin is brought into the clock domain through a two-stage synchronizer and can optionally be inverted before any logic sees it. Per pin, a mode bit picks one of two tests: a comparison against the pin's value one cycle earlier, which fires on any edge, or a comparison against a programmable reference bit, which fires for as long as the pin differs from that reference.

When an interrupt fires, the unit keeps a one-hot record of the single pin that caused it. It also takes a snapshot of the whole port. Both stay frozen until the interrupt is cleared. A configuration bit selects whether a read of the port or a read of the snapshot clears it. The interrupt line has a programmable active level and can be driven push-pull or open-drain. The register access bus sits outside this block. Its register contents arrive as plain inputs, and its read accesses arrive as one-cycle strobes.

Top module: `ioc_capture_unit`

## Requirements
- R1: During and right after reset, the flag and snapshot outputs are all zeros and the interrupt is inactive.
- R2: In change mode (mode bit 0), a change on an enabled pin sets the pending interrupt on the third rising clock edge after the pin changes. Nothing is visible after the second edge.
- R3: In reference mode (mode bit 1), an enabled pin whose seen value differs from its reference bit raises the interrupt. If the mismatch is still present after a clear, the interrupt is raised again on the very next edge.
- R4: A pin whose enable bit is 0 never raises the interrupt.
- R5: The flag output is one-hot while an interrupt is pending and zero otherwise. When several pins trigger in the same cycle, the lowest-numbered pin is the one flagged.
- R6: The snapshot holds the seen port value from the cycle the interrupt fired. While the interrupt is pending, later pin activity changes neither the flag nor the snapshot.
- R7: With the clear-select bit at 0, a port read strobe clears the pending interrupt and the flag on the next edge, and a snapshot read strobe has no effect.
- R8: With the clear-select bit at 1, a snapshot read strobe clears the pending interrupt and the flag, and a port read strobe has no effect.
- R9: Each inversion bit flips the corresponding pin as seen by the port output, by the snapshot and by the reference comparison. Changing an inversion bit on its own does not count as a pin change.
- R10: In push-pull mode the enable output is always 1, and the interrupt output equals the pending state when active-high and its complement when active-low. In open-drain mode the interrupt output is 0 and the enable output equals the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | W | Asynchronous pin levels |
| inv_i | input | W | Per-pin inversion |
| ien_i | input | W | Per-pin interrupt enable |
| mode_i | input | W | Per-pin test: 0 change, 1 reference |
| ref_i | input | W | Per-pin reference values |
| clr_sel_i | input | 1 | 0: port read clears, 1: snapshot read clears |
| act_high_i | input | 1 | Interrupt active level, 1 = high |
| od_i | input | 1 | 1 = open-drain drive |
| port_rd_i | input | 1 | Port read strobe |
| cap_rd_i | input | 1 | Snapshot read strobe |
| port_o | output | W | Synchronized, inverted port value |
| flag_o | output | W | One-hot cause of the pending interrupt |
| cap_o | output | W | Port snapshot taken at the interrupt |
| irq_o | output | 1 | Interrupt line level |
| irq_oe_o | output | 1 | Interrupt line drive enable |

## Verification
The bench samples after the second edge of a pin change, where a design with a missing synchronizer stage would already flag it. It changes pins while an interrupt is pending, so a design that re-captures would show a moved flag or snapshot. Two pins are changed in one cycle to expose a design that flags the wrong pin or sets more than one bit. The bench also issues the non-selected read strobe to catch a clear wired to the wrong source. It holds a reference mismatch across a clear to confirm that the interrupt comes back on the next edge. It flips inversion bits alone, which a design that compares inverted history would mistake for a pin change.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  typedef enum logic {
    CLR_ON_PORT = 1'b0,
    CLR_ON_CAP  = 1'b1
  } clr_src_e;

  typedef struct packed {
    logic act_high;
    logic open_drain;
  } drive_cfg_t;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[k] <= '0;
      else     chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] inv,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] refv,
  output logic [W-1:0] seen,
  output logic [W-1:0] trig
);
  // history is kept on raw levels so an inversion change alone is not an edge
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= raw;
  end

  assign seen = raw ^ inv;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      if (mode[i]) hit = seen[i] ^ refv[i];
      else         hit = raw[i] ^ prev_q[i];
    end
    assign trig[i] = ien[i] & hit;
  end
endmodule

// File: rtl/ioc_latch.sv
module ioc_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] trig,
  input  logic [W-1:0] seen,
  input  logic         clr,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] cap_q,
  output logic         pend_q
);
  logic [W-1:0] first;

  // isolate lowest set bit
  assign first = trig & (~trig + {{(W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      flag_q <= '0;
      cap_q  <= '0;
    end else if (clr) begin
      pend_q <= 1'b0;
      flag_q <= '0;
    end else if (!pend_q && (trig != '0)) begin
      pend_q <= 1'b1;
      flag_q <= first;
      cap_q  <= seen;
    end
  end
endmodule

// File: rtl/ioc_drive.sv
module ioc_drive
  import ioc_pkg::*;
(
  input  logic       pend,
  input  drive_cfg_t cfg,
  output logic       line,
  output logic       oe
);
  always_comb begin
    if (cfg.open_drain) begin
      line = 1'b0;
      oe   = pend;
    end else begin
      line = cfg.act_high ? pend : ~pend;
      oe   = 1'b1;
    end
  end
endmodule

// File: rtl/ioc_capture_unit.sv
module ioc_capture_unit
  import ioc_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] ref_i,
  input  logic         clr_sel_i,
  input  logic         act_high_i,
  input  logic         od_i,
  input  logic         port_rd_i,
  input  logic         cap_rd_i,
  output logic [W-1:0] port_o,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] cap_o,
  output logic         irq_o,
  output logic         irq_oe_o
);
  logic [W-1:0] raw, seen, trig;
  logic         clr, pend;
  clr_src_e     src;
  drive_cfg_t   dcfg;

  assign src  = clr_src_e'(clr_sel_i);
  assign clr  = (src == CLR_ON_CAP) ? cap_rd_i : port_rd_i;
  assign dcfg = '{act_high: act_high_i, open_drain: od_i};

  ioc_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(raw)
  );

  ioc_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .raw(raw), .inv(inv_i), .ien(ien_i),
    .mode(mode_i), .refv(ref_i), .seen(seen), .trig(trig)
  );

  ioc_latch #(.W(W)) u_lat (
    .clk(clk), .rst(rst), .trig(trig), .seen(seen), .clr(clr),
    .flag_q(flag_o), .cap_q(cap_o), .pend_q(pend)
  );

  ioc_drive u_drv (
    .pend(pend), .cfg(dcfg), .line(irq_o), .oe(irq_oe_o)
  );

  assign port_o = seen;
endmodule

// File: rtl/ioc_capture_chk.sv
module ioc_capture_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ien_i,
  input logic         clr_sel_i,
  input logic         od_i,
  input logic         port_rd_i,
  input logic         cap_rd_i,
  input logic [W-1:0] flag_o,
  input logic [W-1:0] cap_o,
  input logic         irq_o,
  input logic         irq_oe_o
);
  logic clr_any;
  assign clr_any = clr_sel_i ? cap_rd_i : port_rd_i;

  assert_flag_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_o));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_o != '0) && !clr_any |=> $stable(flag_o) && $stable(cap_o));

  assert_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (flag_o == '0) && (ien_i == '0) |=> flag_o == '0);

  assert_port_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_sel_i && port_rd_i |=> flag_o == '0);

  assert_cap_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_sel_i && cap_rd_i |=> flag_o == '0);

  assert_open_drain_R10: assert property (@(posedge clk) disable iff (rst)
    od_i |-> !irq_o && (irq_oe_o == (flag_o != '0)));
endmodule

bind ioc_capture_unit ioc_capture_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ien_i(ien_i), .clr_sel_i(clr_sel_i), .od_i(od_i),
  .port_rd_i(port_rd_i), .cap_rd_i(cap_rd_i), .flag_o(flag_o), .cap_o(cap_o),
  .irq_o(irq_o), .irq_oe_o(irq_oe_o)
);

// File: tb/ioc_capture_unit_tb.sv
module ioc_capture_unit_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] pin_i = '0, inv_i = '0, ien_i = '0, mode_i = '0, ref_i = '0;
  logic clr_sel_i = 1'b0, act_high_i = 1'b1, od_i = 1'b0;
  logic port_rd_i = 1'b0, cap_rd_i = 1'b0;
  logic [W-1:0] port_o, flag_o, cap_o;
  logic irq_o, irq_oe_o;

  always #10 clk = ~clk;

  ioc_capture_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .inv_i(inv_i), .ien_i(ien_i),
    .mode_i(mode_i), .ref_i(ref_i), .clr_sel_i(clr_sel_i),
    .act_high_i(act_high_i), .od_i(od_i), .port_rd_i(port_rd_i),
    .cap_rd_i(cap_rd_i), .port_o(port_o), .flag_o(flag_o), .cap_o(cap_o),
    .irq_o(irq_o), .irq_oe_o(irq_oe_o)
  );

  typedef struct {
    string      req;
    logic [W-1:0] flag;
    logic [W-1:0] cap;
    logic [W-1:0] port;
    logic       irq;
    logic       oe;
  } item_t;

  item_t q_exp[$];
  event  sample_ev;
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string r, input logic [W-1:0] f,
                             input logic [W-1:0] c, input logic [W-1:0] p,
                             input logic i, input logic o);
    item_t it;
    it.req = r; it.flag = f; it.cap = c; it.port = p; it.irq = i; it.oe = o;
    q_exp.push_back(it);
    -> sample_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q_exp.size() > 0) begin
        item_t e;
        e = q_exp.pop_front();
        total++;
        if (flag_o !== e.flag || cap_o !== e.cap || port_o !== e.port ||
            irq_o !== e.irq || irq_oe_o !== e.oe) begin
          bad++;
          $display("FAIL %s: got flag=%h cap=%h port=%h irq=%b oe=%b exp flag=%h cap=%h port=%h irq=%b oe=%b",
                   e.req, flag_o, cap_o, port_o, irq_o, irq_oe_o,
                   e.flag, e.cap, e.port, e.irq, e.oe);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_port;
    port_rd_i = 1'b1; step(1); port_rd_i = 1'b0;
  endtask

  task automatic pulse_cap;
    cap_rd_i = 1'b1; step(1); cap_rd_i = 1'b0;
  endtask

  initial begin : driver
    step(3);
    rst = 1'b0;
    expect_item("R1 reset", 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);

    // R4: disabled pin change
    pin_i = 8'h10; step(4);
    expect_item("R4 disabled", 8'h00, 8'h00, 8'h10, 1'b0, 1'b1);
    ien_i = 8'hFF; step(2);
    expect_item("R4 enable no spurious", 8'h00, 8'h00, 8'h10, 1'b0, 1'b1);

    // R2: latency
    pin_i = 8'h14; step(2);
    expect_item("R2 not yet", 8'h00, 8'h00, 8'h14, 1'b0, 1'b1);
    step(1);
    expect_item("R2 change fires", 8'h04, 8'h14, 8'h14, 1'b1, 1'b1);

    // R6: frozen while pending
    pin_i = 8'h15; step(4);
    expect_item("R6 frozen", 8'h04, 8'h14, 8'h15, 1'b1, 1'b1);

    // R7: cap read ignored, port read clears
    pulse_cap();
    expect_item("R7 cap read ignored", 8'h04, 8'h14, 8'h15, 1'b1, 1'b1);
    pulse_port();
    expect_item("R7 port read clears", 8'h00, 8'h14, 8'h15, 1'b0, 1'b1);
    step(2);
    expect_item("R7 stays clear", 8'h00, 8'h14, 8'h15, 1'b0, 1'b1);

    // R5: two pins at once
    pin_i = 8'hB5; step(3);
    expect_item("R5 lowest pin", 8'h20, 8'hB5, 8'hB5, 1'b1, 1'b1);
    pulse_port();
    expect_item("R5 cleared", 8'h00, 8'hB5, 8'hB5, 1'b0, 1'b1);

    // R9: inversion
    inv_i = 8'h0F; step(1);
    expect_item("R9 inverted port, no edge", 8'h00, 8'hB5, 8'hBA, 1'b0, 1'b1);
    step(2);
    expect_item("R9 still no edge", 8'h00, 8'hB5, 8'hBA, 1'b0, 1'b1);

    // R3: reference mode on pin 0 (seen value 0)
    mode_i = 8'h01; ref_i = 8'h00; step(1);
    expect_item("R3 match no irq", 8'h00, 8'hB5, 8'hBA, 1'b0, 1'b1);
    ref_i = 8'h01; step(1);
    expect_item("R3 mismatch fires", 8'h01, 8'hBA, 8'hBA, 1'b1, 1'b1);
    pulse_port();
    expect_item("R3 cleared", 8'h00, 8'hBA, 8'hBA, 1'b0, 1'b1);
    step(1);
    expect_item("R3 re-asserts", 8'h01, 8'hBA, 8'hBA, 1'b1, 1'b1);
    ref_i = 8'h00; pulse_port();
    expect_item("R3 clear with match", 8'h00, 8'hBA, 8'hBA, 1'b0, 1'b1);
    step(2);
    expect_item("R3 no re-assert", 8'h00, 8'hBA, 8'hBA, 1'b0, 1'b1);
    mode_i = 8'h00; inv_i = 8'h00; step(2);
    expect_item("R9 inversion removed", 8'h00, 8'hBA, 8'hB5, 1'b0, 1'b1);

    // R8: snapshot read clears
    clr_sel_i = 1'b1;
    pin_i = 8'hB4; step(3);
    expect_item("R8 fires", 8'h01, 8'hB4, 8'hB4, 1'b1, 1'b1);
    pulse_port();
    expect_item("R8 port read ignored", 8'h01, 8'hB4, 8'hB4, 1'b1, 1'b1);
    pulse_cap();
    expect_item("R8 cap read clears", 8'h00, 8'hB4, 8'hB4, 1'b0, 1'b1);

    // R10: drive modes
    act_high_i = 1'b0; step(1);
    expect_item("R10 active-low idle", 8'h00, 8'hB4, 8'hB4, 1'b1, 1'b1);
    pin_i = 8'hB6; step(3);
    expect_item("R10 active-low asserted", 8'h02, 8'hB6, 8'hB6, 1'b0, 1'b1);
    od_i = 1'b1; step(1);
    expect_item("R10 open-drain active", 8'h02, 8'hB6, 8'hB6, 1'b0, 1'b1);
    pulse_cap();
    expect_item("R10 open-drain released", 8'h00, 8'hB6, 8'hB6, 1'b0, 1'b0);

    step(1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule